// File: doc/BRIEF.md
# Width-Aware Iterative Narrow Compute Array

This block is a two-row array of arithmetic/logic units. It takes four 32-bit operands and returns two 32-bit results. Every unit is only 8 bits wide. A configuration word, captured at start, selects each unit's operation and where each unit takes its operands from. Row 1 reads any of the four operands. Row 2 reads the operands or the row 1 outputs.

A full 32-bit result comes from running the 8-bit datapath over successive byte slices. Each adder keeps its carry-out in a register, and that register becomes the adder's carry-in on the next slice. After the lowest slice, a width check looks at two things: the upper 24 bits of every captured operand, and whether every adder finished that slice with a neutral carry (no carry for an add, no borrow for a subtract). If both hold, every unit's upper result bits are zero, and the job ends after a single pass. Otherwise the controller steps through all four slices.

A processor pipeline uses the block by issuing a start with operands and configuration, then waiting for the one-cycle done pulse.

Top module: `ncaTop`

## Requirements
- R1: A `start` seen while idle captures `inA`..`inD` and `cfgWord`. A `start` during an active job is ignored: the job's timing and results are unchanged.
- R2: Each unit's 3-bit opcode selects its operation: 0 pass operand A, 1 A+B, 2 A−B, 3 AND, 4 OR, 5 XOR. Codes 6 and 7 also pass operand A. Unit opcodes sit at `cfgWord[2:0]` (row 1 unit 0), `[5:3]` (row 1 unit 1), `[8:6]` (row 2 unit 0) and `[11:9]` (row 2 unit 1).
- R3: Row 1 unit k takes operand A from `cfgWord[13+4k:12+4k]` and operand B from `cfgWord[15+4k:14+4k]`. Each of these 2-bit codes selects input 0 to 3 (A to D).
- R4: Row 2 unit k takes operand A from `cfgWord[22+6k:20+6k]` and operand B from `cfgWord[25+6k:23+6k]`. Each 3-bit code means: 0 to 3 select inputs A to D, 4 selects row 1 unit 0, 5 selects row 1 unit 1, and 6 or 7 select zero.
- R5: `resOut0` and `resOut1` are the outputs of row 2 units 0 and 1. They are the exact 32-bit results, with add and subtract taken modulo 2^32.
- R6: Narrow jobs end after one pass. A job is narrow when every input is below 256 and no add carries out of, and no subtract borrows from, the lowest slice. For such a job, `done` is high in the cycle after the first rising edge that follows the start edge.
- R7: Other jobs take four passes. This includes jobs whose inputs are all narrow but whose lowest slice produces a carry or a borrow. For these, `done` is high in the cycle after the fourth rising edge that follows the start edge.
- R8: `done` stays high for exactly one cycle. The results then hold until the next accepted start.
- R9: An accepted start clears both result registers to zero on the same edge.
- R10: With inputs 0x1D, 0x0C, 0x20, 0x08, the mapping row 1 = (A+B, C OR D), row 2 unit 0 = ADD of both row 1 outputs gives 0x51 after a single pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new job; captured only when idle |
| cfgWord | input | 32 | Unit opcodes and operand routing |
| inA | input | 32 | Operand input 0 |
| inB | input | 32 | Operand input 1 |
| inC | input | 32 | Operand input 2 |
| inD | input | 32 | Operand input 3 |
| resOut0 | output | 32 | Result of row 2 unit 0 |
| resOut1 | output | 32 | Result of row 2 unit 1 |
| done | output | 1 | One-cycle pulse when results are complete |

## Verification
Random configurations are applied under two operand regimes. In one, operands are masked to 7 bits, so the one-pass path is taken often. In the other, operands use the full width, so all four passes are needed. Comparing results against a 32-bit reference tells apart a wrong carry chain between slices from a wrong byte-lane write. Directed cases cover narrow inputs that still carry or borrow out of the low slice, and these expose a width check that only looks at input bits. The directed cases also cover the zero routing codes and a start issued mid-job.

// File: rtl/ncaPkg.sv
package ncaPkg;
  localparam int NCA_WORD_W  = 32;
  localparam int NCA_SLICE_W = 8;
  localparam int NCA_PASSES  = NCA_WORD_W / NCA_SLICE_W;
  localparam int NCA_PASS_W  = $clog2(NCA_PASSES);
  localparam int NCA_OP_W    = 3;
  localparam int NCA_CFG_W   = 32;
  localparam int NCA_R1_BASE = 4 * NCA_OP_W;
  localparam int NCA_R2_BASE = NCA_R1_BASE + 8;

  typedef enum logic [NCA_OP_W-1:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5
  } ncaOp_t;

  typedef struct packed {
    logic                  load;
    logic                  step;
    logic                  firstPass;
    logic [NCA_PASS_W-1:0] passIdx;
  } ncaStrobe_t;
endpackage

// File: rtl/ncaSliceAlu.sv
module ncaSliceAlu
  import ncaPkg::*;
#(
  parameter int SLICE_W = NCA_SLICE_W
) (
  input  ncaOp_t             op,
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] res,
  output logic               cout
);
  logic [SLICE_W-1:0] bEff;
  logic [SLICE_W:0]   sum;

  always_comb begin
    bEff = (op == OP_SUB) ? ~b : b;
    sum  = {1'b0, a} + {1'b0, bEff} + {{SLICE_W{1'b0}}, cin};
    cout = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res  = sum[SLICE_W-1:0];
        cout = sum[SLICE_W];
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/ncaCtrl.sv
module ncaCtrl
  import ncaPkg::*;
#(
  parameter int PASSES = NCA_PASSES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       fitsNarrow,
  output ncaStrobe_t strb,
  output logic       done
);
  logic                  busyR;
  logic [NCA_PASS_W-1:0] passR;
  logic                  lastPass;
  logic                  finish;

  assign lastPass = (passR == NCA_PASS_W'(PASSES - 1));
  assign finish   = busyR && (((passR == '0) && fitsNarrow) || lastPass);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR <= 1'b0;
      passR <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (start && !busyR) begin
        busyR <= 1'b1;
        passR <= '0;
      end else if (busyR) begin
        if (finish) busyR <= 1'b0;
        else        passR <= passR + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load      = start && !busyR;
    strb.step      = busyR;
    strb.firstPass = (passR == '0);
    strb.passIdx   = passR;
  end
endmodule

// File: rtl/ncaDatapath.sv
module ncaDatapath
  import ncaPkg::*;
#(
  parameter int WORD_W  = NCA_WORD_W,
  parameter int SLICE_W = NCA_SLICE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ncaStrobe_t           strb,
  input  logic [NCA_CFG_W-1:0] cfgWord,
  input  logic [WORD_W-1:0]    inA,
  input  logic [WORD_W-1:0]    inB,
  input  logic [WORD_W-1:0]    inC,
  input  logic [WORD_W-1:0]    inD,
  output logic [WORD_W-1:0]    res0,
  output logic [WORD_W-1:0]    res1,
  output logic                 fitsNarrow
);
  localparam int N_IN   = 4;
  localparam int N_UNIT = 2;
  localparam int UPPER  = WORD_W - SLICE_W;

  logic [WORD_W-1:0]    opReg [N_IN];
  logic [NCA_CFG_W-1:0] cfgReg;
  logic [2*N_UNIT-1:0]  carryReg;
  logic [SLICE_W-1:0]   sliceIn [N_IN];

  ncaOp_t             r1Op [N_UNIT];
  logic [SLICE_W-1:0] r1A [N_UNIT], r1B [N_UNIT], r1Res [N_UNIT];
  logic               r1Cin [N_UNIT], r1Cout [N_UNIT];
  ncaOp_t             r2Op [N_UNIT];
  logic [SLICE_W-1:0] r2A [N_UNIT], r2B [N_UNIT], r2Res [N_UNIT];
  logic               r2Cin [N_UNIT], r2Cout [N_UNIT];

  always_comb begin
    for (int i = 0; i < N_IN; i++)
      sliceIn[i] = opReg[i][strb.passIdx*SLICE_W +: SLICE_W];
  end

  function automatic logic [SLICE_W-1:0] rowTwoPick(
    input logic [2:0] sel,
    input logic [SLICE_W-1:0] s0, s1, s2, s3, u0, u1
  );
    case (sel)
      3'd0:    return s0;
      3'd1:    return s1;
      3'd2:    return s2;
      3'd3:    return s3;
      3'd4:    return u0;
      3'd5:    return u1;
      default: return '0;
    endcase
  endfunction

  for (genvar u = 0; u < N_UNIT; u++) begin : gRowOne
    assign r1Op[u]  = ncaOp_t'(cfgReg[NCA_OP_W*u +: NCA_OP_W]);
    assign r1A[u]   = sliceIn[cfgReg[NCA_R1_BASE+4*u +: 2]];
    assign r1B[u]   = sliceIn[cfgReg[NCA_R1_BASE+4*u+2 +: 2]];
    assign r1Cin[u] = strb.firstPass ? (r1Op[u] == OP_SUB) : carryReg[u];
    ncaSliceAlu #(.SLICE_W(SLICE_W)) uAlu (
      .op(r1Op[u]), .a(r1A[u]), .b(r1B[u]), .cin(r1Cin[u]),
      .res(r1Res[u]), .cout(r1Cout[u])
    );
  end

  for (genvar u = 0; u < N_UNIT; u++) begin : gRowTwo
    assign r2Op[u]  = ncaOp_t'(cfgReg[NCA_OP_W*(u+2) +: NCA_OP_W]);
    assign r2A[u]   = rowTwoPick(cfgReg[NCA_R2_BASE+6*u +: 3], sliceIn[0],
                        sliceIn[1], sliceIn[2], sliceIn[3], r1Res[0], r1Res[1]);
    assign r2B[u]   = rowTwoPick(cfgReg[NCA_R2_BASE+6*u+3 +: 3], sliceIn[0],
                        sliceIn[1], sliceIn[2], sliceIn[3], r1Res[0], r1Res[1]);
    assign r2Cin[u] = strb.firstPass ? (r2Op[u] == OP_SUB) : carryReg[N_UNIT+u];
    ncaSliceAlu #(.SLICE_W(SLICE_W)) uAlu (
      .op(r2Op[u]), .a(r2A[u]), .b(r2B[u]), .cin(r2Cin[u]),
      .res(r2Res[u]), .cout(r2Cout[u])
    );
  end

  always_comb begin
    logic upperZero;
    logic neutral;
    upperZero = 1'b1;
    for (int i = 0; i < N_IN; i++)
      if (opReg[i][WORD_W-1 -: UPPER] != '0) upperZero = 1'b0;
    neutral = 1'b1;
    for (int u = 0; u < N_UNIT; u++) begin
      if ((r1Op[u] == OP_ADD &&  r1Cout[u]) || (r1Op[u] == OP_SUB && !r1Cout[u])) neutral = 1'b0;
      if ((r2Op[u] == OP_ADD &&  r2Cout[u]) || (r2Op[u] == OP_SUB && !r2Cout[u])) neutral = 1'b0;
    end
    fitsNarrow = upperZero && neutral;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_IN; i++) opReg[i] <= '0;
      cfgReg   <= '0;
      carryReg <= '0;
      res0     <= '0;
      res1     <= '0;
    end else if (strb.load) begin
      opReg[0] <= inA;
      opReg[1] <= inB;
      opReg[2] <= inC;
      opReg[3] <= inD;
      cfgReg   <= cfgWord;
      carryReg <= '0;
      res0     <= '0;
      res1     <= '0;
    end else if (strb.step) begin
      carryReg <= {r2Cout[1], r2Cout[0], r1Cout[1], r1Cout[0]};
      res0[strb.passIdx*SLICE_W +: SLICE_W] <= r2Res[0];
      res1[strb.passIdx*SLICE_W +: SLICE_W] <= r2Res[1];
    end
  end
endmodule

// File: rtl/ncaTop.sv
module ncaTop
  import ncaPkg::*;
#(
  parameter int WORD_W  = NCA_WORD_W,
  parameter int SLICE_W = NCA_SLICE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [NCA_CFG_W-1:0] cfgWord,
  input  logic [WORD_W-1:0]    inA,
  input  logic [WORD_W-1:0]    inB,
  input  logic [WORD_W-1:0]    inC,
  input  logic [WORD_W-1:0]    inD,
  output logic [WORD_W-1:0]    resOut0,
  output logic [WORD_W-1:0]    resOut1,
  output logic                 done
);
  localparam int PASSES = WORD_W / SLICE_W;

  ncaStrobe_t ctrlStrb;
  logic       fitsNarrow;

  ncaCtrl #(.PASSES(PASSES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .fitsNarrow(fitsNarrow),
    .strb(ctrlStrb), .done(done)
  );

  ncaDatapath #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(ctrlStrb), .cfgWord(cfgWord),
    .inA(inA), .inB(inB), .inC(inC), .inD(inD),
    .res0(resOut0), .res1(resOut1), .fitsNarrow(fitsNarrow)
  );
endmodule

// File: rtl/ncaChecker.sv
module ncaChecker
  import ncaPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       done,
  input logic [31:0] res0,
  input logic [31:0] res1,
  input ncaStrobe_t strb,
  input logic       fitsNarrow
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (res0 == 32'd0 && res1 == 32'd0 && strb.step)); // R9

  AST_NARROW_ONE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.firstPass && fitsNarrow) |=> (done && !strb.step)); // R6

  AST_WIDE_ITERATES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.firstPass && !fitsNarrow) |=> (strb.step && strb.passIdx == 2'd1 && !done)); // R7

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.firstPass && strb.passIdx != 2'd3)
      |=> (strb.step && strb.passIdx == $past(strb.passIdx) + 2'd1)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !start) |=> ($stable(res0) && $stable(res1))); // R8
endmodule

bind ncaTop ncaChecker i_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .res0(resOut0), .res1(resOut1), .strb(ctrlStrb), .fitsNarrow(fitsNarrow)
);

// File: tb/test_ncaTop.sv
module test_ncaTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfgWord = '0, inA = '0, inB = '0, inC = '0, inD = '0;
  logic [31:0] resOut0, resOut1;
  logic        done;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  ncaTop i_ncaTop (
    .clk(clk), .rstN(rstN), .start(start), .cfgWord(cfgWord),
    .inA(inA), .inB(inB), .inC(inC), .inD(inD),
    .resOut0(resOut0), .resOut1(resOut1), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(
    input int o0, o1, o2, o3, input int a0, b0, a1, b1, input int c0, d0, c1, d1);
    logic [31:0] w;
    w = '0;
    w[2:0] = 3'(o0); w[5:3] = 3'(o1); w[8:6] = 3'(o2); w[11:9] = 3'(o3);
    w[13:12] = 2'(a0); w[15:14] = 2'(b0); w[17:16] = 2'(a1); w[19:18] = 2'(b1);
    w[22:20] = 3'(c0); w[25:23] = 3'(d0); w[28:26] = 3'(c1); w[31:29] = 3'(d1);
    return w;
  endfunction

  function automatic logic [31:0] alu32(input logic [2:0] op, input logic [31:0] a, b);
    case (op)
      3'd1: return a + b;
      3'd2: return a - b;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      default: return a;
    endcase
  endfunction

  function automatic bit neutralOp(input logic [2:0] op, input logic [31:0] a, b);
    if (op == 3'd1) return (33'(a) + 33'(b)) < 33'd256;
    if (op == 3'd2) return a >= b;
    return 1'b1;
  endfunction

  function automatic logic [31:0] pick2(input logic [2:0] s, input logic [31:0] ins [4], input logic [31:0] u0, u1);
    if (s < 3'd4) return ins[s[1:0]];
    if (s == 3'd4) return u0;
    if (s == 3'd5) return u1;
    return 32'd0;
  endfunction

  task automatic refModel(input logic [31:0] cfg, a, b, c, d,
                          output logic [31:0] e0, e1, output bit narrow);
    logic [31:0] ins [4];
    logic [31:0] x0, y0, x1, y1, u0, u1, p0, q0, p1, q1;
    ins[0] = a; ins[1] = b; ins[2] = c; ins[3] = d;
    x0 = ins[cfg[13:12]]; y0 = ins[cfg[15:14]];
    x1 = ins[cfg[17:16]]; y1 = ins[cfg[19:18]];
    u0 = alu32(cfg[2:0], x0, y0);
    u1 = alu32(cfg[5:3], x1, y1);
    p0 = pick2(cfg[22:20], ins, u0, u1); q0 = pick2(cfg[25:23], ins, u0, u1);
    p1 = pick2(cfg[28:26], ins, u0, u1); q1 = pick2(cfg[31:29], ins, u0, u1);
    e0 = alu32(cfg[8:6], p0, q0);
    e1 = alu32(cfg[11:9], p1, q1);
    narrow = (a < 256) && (b < 256) && (c < 256) && (d < 256) &&
             neutralOp(cfg[2:0], x0, y0) && neutralOp(cfg[5:3], x1, y1) &&
             neutralOp(cfg[8:6], p0, q0) && neutralOp(cfg[11:9], p1, q1);
  endtask

  task automatic runOp(input logic [31:0] cfg, a, b, c, d, input bit intrude, input string tag);
    logic [31:0] e0, e1, h0, h1;
    bit narrow;
    int lat;
    refModel(cfg, a, b, c, d, e0, e1, narrow);
    lat = narrow ? 1 : 4;
    @(negedge clk);
    cfgWord = cfg; inA = a; inB = b; inC = c; inD = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(resOut0 == 0 && resOut1 == 0 && !done, {"R9 cleared at start ", tag}, resOut0, 32'd0);
    for (int cnt = 1; cnt <= lat; cnt++) begin
      @(negedge clk);
      if (intrude && cnt == 1) begin
        start = 1'b1; inA = ~a; inB = ~b; inC = ~c; inD = ~d; cfgWord = ~cfg;
      end else begin
        start = 1'b0;
      end
      chk(done == (cnt == lat), narrow ? {"R6 latency ", tag} : {"R7 latency ", tag},
          32'(done), 32'(cnt == lat));
    end
    start = 1'b0;
    chk(resOut0 == e0, {"R5 result0 ", tag}, resOut0, e0);
    chk(resOut1 == e1, {"R5 result1 ", tag}, resOut1, e1);
    h0 = resOut0; h1 = resOut1;
    @(negedge clk);
    chk(!done && resOut0 == h0 && resOut1 == h1, {"R8 pulse and hold ", tag}, resOut0, h0);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(resOut0 == 0 && resOut1 == 0 && !done, "reset state", resOut0, 32'd0);
    rstN = 1'b1;

    // R10 and R2: worked example, single pass
    runOp(mkCfg(1, 4, 1, 0, 0, 1, 2, 3, 4, 5, 4, 0),
          32'h1D, 32'h0C, 32'h20, 32'h08, 1'b0, "R10 example");
    // R7: narrow inputs with carry out of the low slice
    runOp(mkCfg(1, 2, 4, 0, 0, 1, 2, 3, 4, 5, 5, 0),
          32'hFF, 32'h01, 32'h05, 32'h07, 1'b0, "R7 carry and borrow");
    // R2: logic ops and pass codes 6 and 7
    runOp(mkCfg(3, 5, 6, 7, 0, 1, 2, 3, 4, 5, 5, 4),
          32'hF0F0_1234, 32'h0FF0_FFFF, 32'hAAAA_5555, 32'h1234_8765, 1'b0, "R2 logic ops");
    // R3 and R4: routing, including the zero codes
    runOp(mkCfg(0, 0, 1, 4, 3, 0, 2, 1, 6, 4, 7, 5),
          32'h11, 32'h22, 32'h33, 32'h44, 1'b0, "R3 R4 routing");
    // R5: wrap across the full width
    runOp(mkCfg(1, 2, 1, 2, 0, 1, 2, 3, 4, 0, 5, 3),
          32'hFFFF_FFFF, 32'h1, 32'h0, 32'hFFFF_FFFF, 1'b0, "R5 wrap");
    // R1: start during an active job is ignored
    runOp(mkCfg(1, 1, 1, 2, 0, 1, 2, 3, 4, 5, 5, 4),
          32'h1234_5678, 32'h0101_0101, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R1 busy start");

    for (int n = 0; n < 80; n++) begin
      logic [31:0] m;
      m = (n % 2 == 0) ? 32'h7F : 32'hFFFF_FFFF;
      runOp($urandom, $urandom & m, $urandom & m, $urandom & m, $urandom & m,
            1'b0, (n % 2 == 0) ? "random narrow" : "random wide");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule